// File: doc/BRIEF.md
# Memory-Mapped Character Port

This block is a small character peripheral that hangs off a simple 32-bit load/store bus. It claims one 256-byte window whose base is fixed by a parameter. Four word registers sit inside that window. One pair serves the receive side, which takes bytes from a keyboard. The other pair serves the transmit side, which hands bytes to a display.

Each control register carries two flags:

- a ready flag in bit 0, which the hardware owns;
- an interrupt enable in bit 1, which software owns.

Software can service the port in either of two ways. It can poll the ready flags, or it can arm the enables and wait on a single level-sensitive interrupt line. Both the keyboard input and the display output are byte-wide valid/ready handshakes.

A bus access lasts one cycle. `bus_rdata` is combinational from the decoded address and the current register state. Any side effect of the access (a flag clearing or a byte being loaded) takes effect at the closing clock edge.

Top module: `kbd_mmio_port`

## Requirements
- R1: After reset, the receive ready flag is 0 and the transmit ready flag is 1. Both enables are 0, `irq` is 0, `kb_ready` is 1 and `dsp_valid` is 0.
- R2: The block responds only when `bus_valid` is high and `bus_addr[31:8]` equals the upper bits of the window base. Any other access reads as zero and leaves all state unchanged.
- R3: A keyboard byte is taken on a cycle where `kb_valid` and `kb_ready` are both high. From the next cycle, the receive ready flag (bit 0 of the control word at offset 0x4) reads 1 and `kb_ready` is low until the byte is read.
- R4: A read of offset 0x0 returns the held byte in bits 7:0 with every upper bit zero. From the next cycle, the receive ready flag is 0 and `kb_ready` is 1.
- R5: A write to offset 0x8 while the transmit ready flag is 1 loads `bus_wdata[7:0]` and clears that flag. `dsp_valid` then rises with the byte on `dsp_data`. A write to 0x8 while the flag is 0 is dropped, and `dsp_data` holds steady. A read of 0x8 returns the last byte that was loaded.
- R6: When `dsp_valid` and `dsp_ready` are both high at a clock edge, the transmit ready flag (bit 0 at offset 0xC) reads 1 from the next cycle and `dsp_valid` falls.
- R7: A write to offset 0x4 or 0xC sets that side's enable from `bus_wdata[1]`. Bit 0 of the written word is ignored, because the ready flags change only through R3 to R6.
- R8: `irq` is high exactly while (receive ready and receive enable) or (transmit ready and transmit enable) holds. It is a level and stays high until that condition clears.
- R9: Inside the window, any offset other than 0x0, 0x4, 0x8 or 0xC (including unaligned ones) reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| kb_valid | input | 1 | Keyboard byte offered |
| kb_data | input | 8 | Keyboard byte |
| kb_ready | output | 1 | Port can accept a keyboard byte |
| dsp_valid | output | 1 | Display byte pending |
| dsp_data | output | 8 | Display byte |
| dsp_ready | input | 1 | Display takes the byte |
| irq | output | 1 | Level interrupt request |

## Verification
The receive ready flag is directly visible at the ports as the inverse of `kb_ready`, and the transmit ready flag as the inverse of `dsp_valid`. A flag that sets or clears on the wrong edge therefore shows up on the very next cycle. It also shows up in `irq` on that cycle once the matching enable is armed. A wrong held byte or a bad decode only appears when software reads it back, or when the display takes the byte. For that reason the bench checks every handed-over byte against a queue of the bytes it wrote, in order.

// File: rtl/kbd_mmio_pkg.sv
package kbd_mmio_pkg;
   typedef enum logic [1:0] {
      REG_RX_DATA = 2'd0,
      REG_RX_CTL  = 2'd1,
      REG_TX_DATA = 2'd2,
      REG_TX_CTL  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic     hit;
      logic     we;
      reg_sel_e sel;
   } acc_t;

   localparam int RDY_BIT = 0;
   localparam int IE_BIT  = 1;
endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec
   import kbd_mmio_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                WIN_BITS = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
) (
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output acc_t              acc
);
   localparam int TAG_W = ADDR_W - WIN_BITS;

   generate
      if (WIN_BITS < 4)
         $error("window must hold the four registers");
      if (TAG_W < 1)
         $error("window must be smaller than the address space");
   endgenerate

   logic                cs;
   logic                mapped;
   logic [WIN_BITS-1:0] off;

   assign off    = bus_addr[WIN_BITS-1:0];
   assign cs     = bus_valid && (bus_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
   assign mapped = (off[WIN_BITS-1:4] == '0) && (off[1:0] == 2'b00);

   always_comb begin
      acc.hit = cs && mapped;
      acc.we  = bus_we;
      acc.sel = reg_sel_e'(off[3:2]);
   end
endmodule

// File: rtl/kbd_rx_chan.sv
module kbd_rx_chan #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kb_valid,
   input  logic [CHAR_W-1:0] kb_data,
   output logic              kb_ready,
   input  logic              rd_take,
   input  logic              ie_wr,
   input  logic              ie_val,
   output logic              rdy,
   output logic              ie,
   output logic [CHAR_W-1:0] held
);
   logic take;

   assign kb_ready = !rdy;
   assign take     = kb_valid && kb_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy  <= 1'b0;
         ie   <= 1'b0;
         held <= '0;
      end else begin
         if (take) begin
            rdy  <= 1'b1;
            held <= kb_data;
         end else if (rd_take) begin
            rdy <= 1'b0;
         end
         if (ie_wr) ie <= ie_val;
      end
   end
endmodule

// File: rtl/kbd_tx_chan.sv
module kbd_tx_chan #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [CHAR_W-1:0] wr_byte,
   input  logic              ie_wr,
   input  logic              ie_val,
   output logic              dsp_valid,
   output logic [CHAR_W-1:0] dsp_data,
   input  logic              dsp_ready,
   output logic              rdy,
   output logic              ie
);
   logic load;

   assign dsp_valid = !rdy;
   assign load      = wr_load && rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy      <= 1'b1;
         ie       <= 1'b0;
         dsp_data <= '0;
      end else begin
         if (load) begin
            rdy      <= 1'b0;
            dsp_data <= wr_byte;
         end else if (dsp_valid && dsp_ready) begin
            rdy <= 1'b1;
         end
         if (ie_wr) ie <= ie_val;
      end
   end
endmodule

// File: rtl/kbd_mmio_port.sv
module kbd_mmio_port
   import kbd_mmio_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter int                CHAR_W   = 8,
   parameter int                WIN_BITS = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              kb_valid,
   input  logic [CHAR_W-1:0] kb_data,
   output logic              kb_ready,
   output logic              dsp_valid,
   output logic [CHAR_W-1:0] dsp_data,
   input  logic              dsp_ready,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CHAR_W;

   generate
      if (CHAR_W < 2 || PAD_W < 0)
         $error("character must be 2..DATA_W bits wide");
   endgenerate

   acc_t              acc;
   logic              rd_rx_data;
   logic              wr_rx_ctl;
   logic              wr_tx_data;
   logic              wr_tx_ctl;
   logic              rx_rdy, rx_ie, tx_rdy, tx_ie;
   logic [CHAR_W-1:0] rx_held;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

   kbd_addr_dec #(
      .ADDR_W  (ADDR_W),
      .WIN_BITS(WIN_BITS),
      .WIN_BASE(WIN_BASE)
   ) u_dec (
      .bus_valid(bus_valid),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .acc      (acc)
   );

   assign rd_rx_data = acc.hit && !acc.we && (acc.sel == REG_RX_DATA);
   assign wr_rx_ctl  = acc.hit &&  acc.we && (acc.sel == REG_RX_CTL);
   assign wr_tx_data = acc.hit &&  acc.we && (acc.sel == REG_TX_DATA);
   assign wr_tx_ctl  = acc.hit &&  acc.we && (acc.sel == REG_TX_CTL);

   kbd_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .kb_valid(kb_valid),
      .kb_data (kb_data),
      .kb_ready(kb_ready),
      .rd_take (rd_rx_data),
      .ie_wr   (wr_rx_ctl),
      .ie_val  (bus_wdata[IE_BIT]),
      .rdy     (rx_rdy),
      .ie      (rx_ie),
      .held    (rx_held)
   );

   kbd_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_load  (wr_tx_data),
      .wr_byte  (bus_wdata[CHAR_W-1:0]),
      .ie_wr    (wr_tx_ctl),
      .ie_val   (bus_wdata[IE_BIT]),
      .dsp_valid(dsp_valid),
      .dsp_data (dsp_data),
      .dsp_ready(dsp_ready),
      .rdy      (tx_rdy),
      .ie       (tx_ie)
   );

   always_comb begin
      bus_rdata = '0;
      if (acc.hit && !acc.we) begin
         case (acc.sel)
            REG_RX_DATA: bus_rdata = DATA_W'(rx_held);
            REG_RX_CTL:  bus_rdata = DATA_W'({rx_ie, rx_rdy});
            REG_TX_DATA: bus_rdata = DATA_W'(dsp_data);
            REG_TX_CTL:  bus_rdata = DATA_W'({tx_ie, tx_rdy});
            default:     bus_rdata = '0;
         endcase
      end
   end

   assign irq = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);
endmodule

// File: rtl/kbd_mmio_chk.sv
module kbd_mmio_chk #(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter int                CHAR_W   = 8,
   parameter int                WIN_BITS = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              kb_valid,
   input logic              kb_ready,
   input logic              dsp_valid,
   input logic [CHAR_W-1:0] dsp_data,
   input logic              dsp_ready,
   input logic              irq
);
   // R3
   rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kb_valid && kb_ready |=> !kb_ready);

   // R4
   rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_we && bus_addr == WIN_BASE && !kb_ready |=> kb_ready);

   // R5
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid && !dsp_ready |=> dsp_valid && $stable(dsp_data));

   // R6
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid && dsp_ready |=> !dsp_valid);

   // R2
   off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[ADDR_W-1:WIN_BITS] != WIN_BASE[ADDR_W-1:WIN_BITS]) |-> bus_rdata == '0);

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((bus_valid && bus_we) || (kb_valid && kb_ready) || (dsp_valid && dsp_ready)));
endmodule

bind kbd_mmio_port kbd_mmio_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CHAR_W  (CHAR_W),
   .WIN_BITS(WIN_BITS),
   .WIN_BASE(WIN_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_valid(bus_valid),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .kb_valid (kb_valid),
   .kb_ready (kb_ready),
   .dsp_valid(dsp_valid),
   .dsp_data (dsp_data),
   .dsp_ready(dsp_ready),
   .irq      (irq)
);

// File: tb/kbd_mmio_port_bench.sv
module kbd_mmio_port_bench;
   localparam logic [31:0] BASE = 32'hF000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        kb_valid = 1'b0;
   logic [7:0]  kb_data = '0;
   logic        kb_ready;
   logic        dsp_valid;
   logic [7:0]  dsp_data;
   logic        dsp_ready = 1'b0;
   logic        irq;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];

   always #2 clk = !clk;

   kbd_mmio_port u_kbd_mmio_port (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
      .dsp_valid(dsp_valid), .dsp_data(dsp_data), .dsp_ready(dsp_ready),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic kb_push(input logic [7:0] b);
      @(negedge clk);
      kb_valid = 1'b1; kb_data = b;
      @(posedge clk); #1;
      kb_valid = 1'b0;
   endtask

   // driver: expected display byte goes to the scoreboard queue
   task automatic tx_send(input logic [7:0] b);
      exp_q.push_back(b);
      bus_wr(BASE + 32'h8, {24'h0, b});
   endtask

   task automatic settle;
      @(negedge clk); #1;
   endtask

   // monitor: one pop per display handshake (R6)
   initial forever begin
      @(negedge clk); #1;
      if (rst_n && dsp_valid && dsp_ready) begin
         if (exp_q.size() == 0) chk("R6 unexpected byte", {24'h0, dsp_data}, 32'hxx);
         else chk("R6 display byte", {24'h0, dsp_data}, {24'h0, exp_q.pop_front()});
      end
   end

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1 reset state
      chk("R1 kb_ready", kb_ready, 1);
      chk("R1 dsp_valid", dsp_valid, 0);
      chk("R1 irq", irq, 0);
      rd_chk("R1 rx ctl", BASE + 32'h4, 32'h0);
      rd_chk("R1 tx ctl", BASE + 32'hC, 32'h1);

      // R3 arrival
      kb_push(8'h41);
      settle();
      chk("R3 kb_ready low", kb_ready, 0);
      rd_chk("R3 rx ready", BASE + 32'h4, 32'h1);
      chk("R8 irq off without enable", irq, 0);

      // R7 bit0 ignored, bit1 sets enable
      bus_wr(BASE + 32'h4, 32'h0);
      rd_chk("R7 ready kept", BASE + 32'h4, 32'h1);
      bus_wr(BASE + 32'h4, 32'h3);
      rd_chk("R7 enable set", BASE + 32'h4, 32'h3);
      settle();
      chk("R8 irq rx", irq, 1);

      // R2 outside window
      rd_chk("R2 read outside", BASE + 32'h104, 32'h0);
      bus_wr(BASE + 32'h104, 32'h0);
      rd_chk("R2 write outside ignored", BASE + 32'h4, 32'h3);
      rd_chk("R2 read below", BASE - 32'h4, 32'h0);

      // R9 unmapped offsets
      rd_chk("R9 offset 0x10", BASE + 32'h10, 32'h0);
      rd_chk("R9 offset 0x5", BASE + 32'h5, 32'h0);
      bus_wr(BASE + 32'h14, 32'h0);
      rd_chk("R9 write ignored", BASE + 32'h4, 32'h3);

      // R4 data read and clear
      rd_chk("R4 rx byte", BASE, 32'h41);
      settle();
      chk("R4 kb_ready back", kb_ready, 1);
      chk("R8 irq cleared", irq, 0);
      rd_chk("R4 ready cleared", BASE + 32'h4, 32'h2);
      kb_push(8'h7E);
      settle();
      chk("R8 irq level again", irq, 1);
      rd_chk("R4 second byte", BASE, 32'h7E);
      bus_wr(BASE + 32'h4, 32'h0);

      // R5 transmit load, busy write dropped
      tx_send(8'h48);
      settle();
      chk("R5 dsp_valid", dsp_valid, 1);
      chk("R5 dsp_data", {24'h0, dsp_data}, 32'h48);
      rd_chk("R5 tx ready cleared", BASE + 32'hC, 32'h0);
      bus_wr(BASE + 32'h8, 32'h55);
      settle();
      chk("R5 busy write dropped", {24'h0, dsp_data}, 32'h48);
      rd_chk("R5 tx data readback", BASE + 32'h8, 32'h48);
      bus_wr(BASE + 32'hC, 32'h2);
      settle();
      chk("R8 irq off while tx busy", irq, 0);

      // R6 handshake
      @(negedge clk);
      dsp_ready = 1'b1;
      @(negedge clk);
      dsp_ready = 1'b0;
      #1;
      chk("R6 dsp_valid low", dsp_valid, 0);
      chk("R8 irq tx", irq, 1);
      rd_chk("R6 tx ready", BASE + 32'hC, 32'h3);

      // second byte with display always ready
      @(negedge clk);
      dsp_ready = 1'b1;
      tx_send(8'h21);
      repeat (3) settle();
      dsp_ready = 1'b0;
      chk("R6 queue drained", exp_q.size(), 0);
      bus_wr(BASE + 32'hC, 32'h1);
      settle();
      chk("R8 irq off after disable", irq, 0);
      rd_chk("R7 tx ctl after disable", BASE + 32'hC, 32'h1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule